// File: doc/BRIEF.md
# DMA Channel Register File

This block is the processor-facing register file of a four-channel DMA controller. The processor reaches it through an 8-bit data bus and a 4-bit port offset. Each channel has a 16-bit address register and a 16-bit count register. Each of these holds a base copy and a working (current) copy. Because the bus is only 8 bits wide, a single shared byte-pointer flip-flop decides whether an access to one of these registers reaches the low byte or the high byte.

Besides the channel registers, the block decodes a set of control ports: command, software request, per-channel mask, mode, pointer clear, master clear, mask clear and whole mask write. It also provides the status and temporary readback ports. It drives each channel's current address and count, mode, mask, software request and the command byte towards the transfer engine. The engine in turn hands back updated working values, terminal-count pulses, hardware request levels and a temporary data byte. Software programs the count as the number of transfers minus one, so 0x0000 means one transfer and 0xFFFF means 65536.

Top module: `dmac_regfile`

## Requirements
- R1: A shared pointer flip-flop selects the byte of a channel register access: 0 selects the low byte and 1 selects the high byte. Every read or write of offsets 0x0 to 0x7 toggles it. A write to offset 0xC clears it, so the next such access reaches the low byte.
- R2: Channel n has its address register at offset 2n and its count register at offset 2n+1. A byte write updates that byte of both the base copy and the current copy. A read returns the selected byte of the current copy. The current values appear on `cur_addr_o` and `cur_cnt_o`, with channel n at bits [16n+15:16n].
- R3: A write to offset 0xA selects a channel with data bits 1:0. If data bit 2 is 1, it sets that channel's bit in `mask_o`; if bit 2 is 0, it clears that bit.
- R4: A write to offset 0xB selects a channel with data bits 1:0 and stores data bits 7:2 as that channel's 6-bit mode on `mode_o[6n+5:6n]`. For example, 0x44 stores 0x11, 0x48 stores 0x12 and 0xC0 stores 0x30.
- R5: A write to offset 0x8 loads `cmd_o`. A write to offset 0x9 selects a channel with data bits 1:0 and sets (bit 2 = 1) or clears (bit 2 = 0) that channel's bit in `sreq_o`.
- R6: A read of offset 0x8 returns the terminal-count flags in bits 3:0 and the pending requests in bits 7:4. A flag is set by a pulse on `eng_tc_i`. A request is pending when the software request or `eng_req_i` is set. The read clears the flags, but a terminal-count pulse in the same cycle as the read stays set.
- R7: A write to offset 0xD sets all mask bits and clears the pointer, command, software requests, terminal-count flags and temporary byte. It leaves the address, count and mode registers unchanged.
- R8: A write to offset 0xE clears all mask bits. A write to offset 0xF loads the mask from data bits 3:0.
- R9: A pulse on `eng_ld_i[n]` copies the engine's address and count into channel n's current copies. A bus byte write to one of these registers in the same cycle wins for that register.
- R10: On a pulse of `eng_tc_i[n]`, if mode bit 2 (written as data bit 4) is set, the current copies reload from the base copies, and this reload wins over `eng_ld_i[n]`. If mode bit 2 is clear, the terminal-count pulse leaves the current copies alone.
- R11: A read of offset 0xD returns the byte last loaded with `eng_temp_ld_i`. Reads of offsets 0x9, 0xA, 0xB, 0xC, 0xE and 0xF return 0x00 and do not toggle the pointer.
- R12: After reset all four mask bits are set. The pointer, command, requests, flags, modes, temporary byte and all address and count copies are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs_i | input | 1 | Bus select |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access (ignored while writing) |
| bus_off_i | input | 4 | Port offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while the read strobe is high, otherwise 0 |
| eng_ld_i | input | 4 | Per-channel load of current address and count from the engine |
| eng_addr_i | input | 64 | Engine address, 16 bits per channel |
| eng_cnt_i | input | 64 | Engine count, 16 bits per channel |
| eng_tc_i | input | 4 | Per-channel terminal-count pulse |
| eng_req_i | input | 4 | Per-channel hardware request level |
| eng_temp_ld_i | input | 1 | Load strobe for the temporary byte |
| eng_temp_i | input | 8 | Temporary byte from the engine |
| cur_addr_o | output | 64 | Current address per channel |
| cur_cnt_o | output | 64 | Current count per channel |
| mode_o | output | 24 | Mode per channel, 6 bits each |
| mask_o | output | 4 | Channel mask bits |
| cmd_o | output | 8 | Command byte |
| sreq_o | output | 4 | Software request bits |

## Verification
The bench builds the block with its default package values: four channels with 16-bit registers and 6-bit modes. This makes every channel-select code and both byte halves of every register reachable through the real port map. On top of a per-cycle comparison against a behavioural model, the bench drives the collisions that carry a priority. These are a bus write meeting an engine load, a terminal-count reload meeting an engine load, and a status read meeting a fresh terminal-count pulse. It also walks the pointer through clears, toggles and accesses to ports that must not move it.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int NUM_CH     = 4;
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int BYTE_W     = 8;
    localparam int REG_W      = 2 * BYTE_W;
    localparam int MODE_W     = BYTE_W - CH_W;
    localparam int OFF_W      = 4;
    localparam int MODE_AUTO  = 2;

    localparam logic [OFF_W-1:0] OFF_CMD     = 4'h8;
    localparam logic [OFF_W-1:0] OFF_REQ     = 4'h9;
    localparam logic [OFF_W-1:0] OFF_SMASK   = 4'hA;
    localparam logic [OFF_W-1:0] OFF_MODE    = 4'hB;
    localparam logic [OFF_W-1:0] OFF_CLRPTR  = 4'hC;
    localparam logic [OFF_W-1:0] OFF_MCLR    = 4'hD;
    localparam logic [OFF_W-1:0] OFF_CLRMASK = 4'hE;
    localparam logic [OFF_W-1:0] OFF_ALLMASK = 4'hF;

    typedef struct packed {
        logic [REG_W-1:0]  base_addr;
        logic [REG_W-1:0]  cur_addr;
        logic [REG_W-1:0]  base_cnt;
        logic [REG_W-1:0]  cur_cnt;
        logic [MODE_W-1:0] mode;
    } chan_st_t;

    typedef struct packed {
        logic              ptr;
        logic [NUM_CH-1:0] mask;
        logic [BYTE_W-1:0] cmd;
        logic [NUM_CH-1:0] sreq;
        logic [NUM_CH-1:0] tc;
        logic [BYTE_W-1:0] temp;
    } ctl_st_t;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_i,
    input  logic              wr_cnt_i,
    input  logic              wr_mode_i,
    input  logic              hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              eng_ld_i,
    input  logic [REG_W-1:0]  eng_addr_i,
    input  logic [REG_W-1:0]  eng_cnt_i,
    input  logic              tc_i,
    output logic [REG_W-1:0]  cur_addr_o,
    output logic [REG_W-1:0]  cur_cnt_o,
    output logic [MODE_W-1:0] mode_o
);
    chan_st_t st_d, st_q;

    function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] v,
                                                  input logic hi,
                                                  input logic [BYTE_W-1:0] b);
        logic [REG_W-1:0] r;
        r = v;
        if (hi) r[REG_W-1:BYTE_W] = b;
        else    r[BYTE_W-1:0]     = b;
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        // reload on terminal count outranks an engine load
        if (tc_i && st_q.mode[MODE_AUTO]) begin
            st_d.cur_addr = st_q.base_addr;
            st_d.cur_cnt  = st_q.base_cnt;
        end else if (eng_ld_i) begin
            st_d.cur_addr = eng_addr_i;
            st_d.cur_cnt  = eng_cnt_i;
        end
        // a bus byte write outranks both for the register it targets
        if (wr_addr_i) begin
            st_d.base_addr = put_byte(st_q.base_addr, hi_i, wdata_i);
            st_d.cur_addr  = put_byte(st_q.cur_addr, hi_i, wdata_i);
        end
        if (wr_cnt_i) begin
            st_d.base_cnt = put_byte(st_q.base_cnt, hi_i, wdata_i);
            st_d.cur_cnt  = put_byte(st_q.cur_cnt, hi_i, wdata_i);
        end
        if (wr_mode_i) st_d.mode = wdata_i[BYTE_W-1:CH_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr_o = st_q.cur_addr;
    assign cur_cnt_o  = st_q.cur_cnt;
    assign mode_o     = st_q.mode;
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [NUM_CH-1:0] tc_i,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              temp_ld_i,
    input  logic [BYTE_W-1:0] temp_i,
    output logic              ptr_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic [BYTE_W-1:0] cmd_o,
    output logic [NUM_CH-1:0] sreq_o,
    output logic [BYTE_W-1:0] status_o,
    output logic [BYTE_W-1:0] temp_o
);
    ctl_st_t          st_d, st_q;
    logic [CH_W-1:0]  sel;

    assign sel = wdata_i[CH_W-1:0];

    always_comb begin
        st_d = st_q;
        if ((wr_i || rd_i) && !off_i[OFF_W-1]) st_d.ptr = ~st_q.ptr;
        if (rd_i && off_i == OFF_CMD) st_d.tc = '0;
        st_d.tc = st_d.tc | tc_i;
        if (temp_ld_i) st_d.temp = temp_i;
        if (wr_i) begin
            case (off_i)
                OFF_CMD:     st_d.cmd = wdata_i;
                OFF_REQ:     st_d.sreq[sel] = wdata_i[CH_W];
                OFF_SMASK:   st_d.mask[sel] = wdata_i[CH_W];
                OFF_CLRPTR:  st_d.ptr = 1'b0;
                OFF_MCLR: begin
                    st_d.mask = '1;
                    st_d.ptr  = 1'b0;
                    st_d.cmd  = '0;
                    st_d.sreq = '0;
                    st_d.tc   = '0;
                    st_d.temp = '0;
                end
                OFF_CLRMASK: st_d.mask = '0;
                OFF_ALLMASK: st_d.mask = wdata_i[NUM_CH-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o    = st_q.ptr;
    assign mask_o   = st_q.mask;
    assign cmd_o    = st_q.cmd;
    assign sreq_o   = st_q.sreq;
    assign status_o = {st_q.sreq | req_i, st_q.tc};
    assign temp_o   = st_q.temp;
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_cs_i,
    input  logic                     bus_wr_i,
    input  logic                     bus_rd_i,
    input  logic [OFF_W-1:0]         bus_off_i,
    input  logic [BYTE_W-1:0]        bus_wdata_i,
    output logic [BYTE_W-1:0]        bus_rdata_o,
    input  logic [NUM_CH-1:0]        eng_ld_i,
    input  logic [NUM_CH*REG_W-1:0]  eng_addr_i,
    input  logic [NUM_CH*REG_W-1:0]  eng_cnt_i,
    input  logic [NUM_CH-1:0]        eng_tc_i,
    input  logic [NUM_CH-1:0]        eng_req_i,
    input  logic                     eng_temp_ld_i,
    input  logic [BYTE_W-1:0]        eng_temp_i,
    output logic [NUM_CH*REG_W-1:0]  cur_addr_o,
    output logic [NUM_CH*REG_W-1:0]  cur_cnt_o,
    output logic [NUM_CH*MODE_W-1:0] mode_o,
    output logic [NUM_CH-1:0]        mask_o,
    output logic [BYTE_W-1:0]        cmd_o,
    output logic [NUM_CH-1:0]        sreq_o
);
    logic              wr_s, rd_s, ptr_w;
    logic [BYTE_W-1:0] status_w, temp_w;
    logic [CH_W-1:0]   rsel;
    logic [REG_W-1:0]  rword;

    assign wr_s = bus_cs_i & bus_wr_i;
    assign rd_s = bus_cs_i & bus_rd_i & ~bus_wr_i;

    dmac_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_s), .rd_i(rd_s),
        .off_i(bus_off_i), .wdata_i(bus_wdata_i), .tc_i(eng_tc_i),
        .req_i(eng_req_i), .temp_ld_i(eng_temp_ld_i), .temp_i(eng_temp_i),
        .ptr_o(ptr_w), .mask_o(mask_o), .cmd_o(cmd_o), .sreq_o(sreq_o),
        .status_o(status_w), .temp_o(temp_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic wr_addr, wr_cnt, wr_mode;
        assign wr_addr = wr_s && (bus_off_i == OFF_W'(2 * g));
        assign wr_cnt  = wr_s && (bus_off_i == OFF_W'(2 * g + 1));
        assign wr_mode = wr_s && (bus_off_i == OFF_MODE) &&
                         (bus_wdata_i[CH_W-1:0] == CH_W'(g));
        dmac_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_addr_i(wr_addr), .wr_cnt_i(wr_cnt), .wr_mode_i(wr_mode),
            .hi_i(ptr_w), .wdata_i(bus_wdata_i),
            .eng_ld_i(eng_ld_i[g]),
            .eng_addr_i(eng_addr_i[g*REG_W +: REG_W]),
            .eng_cnt_i(eng_cnt_i[g*REG_W +: REG_W]),
            .tc_i(eng_tc_i[g]),
            .cur_addr_o(cur_addr_o[g*REG_W +: REG_W]),
            .cur_cnt_o(cur_cnt_o[g*REG_W +: REG_W]),
            .mode_o(mode_o[g*MODE_W +: MODE_W])
        );
    end

    assign rsel  = bus_off_i[CH_W:1];
    assign rword = bus_off_i[0] ? cur_cnt_o[rsel*REG_W +: REG_W]
                                : cur_addr_o[rsel*REG_W +: REG_W];

    always_comb begin
        bus_rdata_o = '0;
        if (rd_s) begin
            if (!bus_off_i[OFF_W-1])
                bus_rdata_o = ptr_w ? rword[REG_W-1:BYTE_W] : rword[BYTE_W-1:0];
            else if (bus_off_i == OFF_CMD)
                bus_rdata_o = status_w;
            else if (bus_off_i == OFF_MCLR)
                bus_rdata_o = temp_w;
        end
    end
endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk
    import dmac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [OFF_W-1:0]  bus_off_i,
    input logic [BYTE_W-1:0] bus_wdata_i,
    input logic [NUM_CH-1:0] eng_tc_i,
    input logic [NUM_CH-1:0] mask_o,
    input logic [BYTE_W-1:0] cmd_o,
    input logic              ptr,
    input logic [BYTE_W-1:0] status
);
    logic wr, rd;
    assign wr = bus_cs_i && bus_wr_i;
    assign rd = bus_cs_i && bus_rd_i && !bus_wr_i;

    assert_ptr_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr || rd) && !bus_off_i[3]) |=> (ptr != $past(ptr)));
    assert_ptr_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_off_i == OFF_CLRPTR) |=> !ptr);
    assert_single_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_off_i == OFF_SMASK) |=> (mask_o[$past(bus_wdata_i[1:0])] == $past(bus_wdata_i[2])));
    assert_cmd_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_off_i == OFF_CMD) |=> (cmd_o == $past(bus_wdata_i)));
    assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_off_i == OFF_CMD && eng_tc_i == '0) |=> (status[3:0] == 4'h0));
    assert_master_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_off_i == OFF_MCLR) |=> (mask_o == '1 && cmd_o == '0 && !ptr));
    assert_clear_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_off_i == OFF_CLRMASK) |=> (mask_o == '0));
    assert_all_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_off_i == OFF_ALLMASK) |=> (mask_o == $past(bus_wdata_i[3:0])));
endmodule

bind dmac_regfile dmac_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_cs_i(bus_cs_i), .bus_wr_i(bus_wr_i),
    .bus_rd_i(bus_rd_i), .bus_off_i(bus_off_i), .bus_wdata_i(bus_wdata_i),
    .eng_tc_i(eng_tc_i), .mask_o(mask_o), .cmd_o(cmd_o),
    .ptr(ptr_w), .status(status_w)
);

// File: tb/dmac_regfile_tb.sv
module dmac_regfile_tb;
    import dmac_pkg::*;

    logic clk = 0, rst_n = 0;
    logic bus_cs = 0, bus_wr = 0, bus_rd = 0;
    logic [3:0] bus_off = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic [3:0] eng_ld = 0, eng_tc = 0, eng_req = 0;
    logic [63:0] eng_addr = 0, eng_cnt = 0;
    logic eng_temp_ld = 0;
    logic [7:0] eng_temp = 0;
    logic [63:0] cur_addr, cur_cnt;
    logic [23:0] mode;
    logic [3:0] mask, sreq;
    logic [7:0] cmd;

    int checks = 0, errors = 0;
    bit done = 0;

    dmac_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_i(bus_cs), .bus_wr_i(bus_wr),
        .bus_rd_i(bus_rd), .bus_off_i(bus_off), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .eng_ld_i(eng_ld), .eng_addr_i(eng_addr),
        .eng_cnt_i(eng_cnt), .eng_tc_i(eng_tc), .eng_req_i(eng_req),
        .eng_temp_ld_i(eng_temp_ld), .eng_temp_i(eng_temp),
        .cur_addr_o(cur_addr), .cur_cnt_o(cur_cnt), .mode_o(mode),
        .mask_o(mask), .cmd_o(cmd), .sreq_o(sreq)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    int m_base_a[4], m_cur_a[4], m_base_c[4], m_cur_c[4], m_mode[4];
    int m_cmd, m_temp;
    bit [3:0] m_mask, m_sreq, m_tc;
    bit m_ptr;

    function automatic int setb(int v, bit hi, int b);
        return hi ? ((v & 'hFF) | ((b & 'hFF) << 8)) : ((v & 'hFF00) | (b & 'hFF));
    endfunction

    always @(posedge clk) begin : model
        int o, ch;
        bit w, r;
        int oa[4], oc[4];
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_base_a[i] = 0; m_cur_a[i] = 0; m_base_c[i] = 0; m_cur_c[i] = 0; m_mode[i] = 0;
            end
            m_cmd = 0; m_temp = 0; m_mask = 4'hF; m_sreq = 0; m_tc = 0; m_ptr = 0;
        end else begin
            o = bus_off; w = bus_cs && bus_wr; r = bus_cs && bus_rd && !bus_wr;
            for (int i = 0; i < 4; i++) begin
                oa[i] = m_cur_a[i]; oc[i] = m_cur_c[i];
                if (eng_tc[i] && ((m_mode[i] >> 2) & 1) == 1) begin
                    m_cur_a[i] = m_base_a[i]; m_cur_c[i] = m_base_c[i];
                end else if (eng_ld[i]) begin
                    m_cur_a[i] = eng_addr[i*16 +: 16]; m_cur_c[i] = eng_cnt[i*16 +: 16];
                end
            end
            if (w && o < 8) begin
                ch = o / 2;
                if (o % 2 == 0) begin
                    m_base_a[ch] = setb(m_base_a[ch], m_ptr, bus_wdata);
                    m_cur_a[ch]  = setb(oa[ch], m_ptr, bus_wdata);
                end else begin
                    m_base_c[ch] = setb(m_base_c[ch], m_ptr, bus_wdata);
                    m_cur_c[ch]  = setb(oc[ch], m_ptr, bus_wdata);
                end
            end
            if (r && o == 8) m_tc = 0;
            m_tc = m_tc | eng_tc;
            if (eng_temp_ld) m_temp = eng_temp;
            if ((w || r) && o < 8) m_ptr = !m_ptr;
            if (w) begin
                case (o)
                    8:  m_cmd = bus_wdata;
                    9:  m_sreq[bus_wdata[1:0]] = bus_wdata[2];
                    10: m_mask[bus_wdata[1:0]] = bus_wdata[2];
                    11: m_mode[bus_wdata[1:0]] = bus_wdata >> 2;
                    12: m_ptr = 0;
                    13: begin m_mask = 4'hF; m_ptr = 0; m_cmd = 0; m_sreq = 0; m_tc = 0; m_temp = 0; end
                    14: m_mask = 0;
                    15: m_mask = bus_wdata[3:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic int exp_rdata();
        int v;
        if (!(bus_cs && bus_rd && !bus_wr)) return 0;
        if (bus_off < 8) begin
            v = bus_off[0] ? m_cur_c[bus_off / 2] : m_cur_a[bus_off / 2];
            return m_ptr ? ((v >> 8) & 255) : (v & 255);
        end
        if (bus_off == 8) return {(m_sreq | eng_req), m_tc};
        if (bus_off == 13) return m_temp;
        return 0;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the clock edges
    always @(negedge clk) begin
        #5;
        if (rst_n && !done) begin
            for (int i = 0; i < 4; i++) begin
                check("R2 cur_addr", cur_addr[i*16 +: 16], m_cur_a[i]);
                check("R2 cur_cnt", cur_cnt[i*16 +: 16], m_cur_c[i]);
                check("R4 mode", mode[i*6 +: 6], m_mode[i]);
            end
            check("R3 mask", mask, m_mask);
            check("R5 cmd", cmd, m_cmd);
            check("R5 sreq", sreq, m_sreq);
            check("R1 rdata", bus_rdata, exp_rdata());
        end
    end

    task automatic wr_reg(input int o, input int d);
        @(negedge clk);
        bus_cs = 1; bus_wr = 1; bus_off = o[3:0]; bus_wdata = d[7:0];
        @(negedge clk);
        bus_cs = 0; bus_wr = 0;
    endtask

    task automatic rd_reg(input int o, output int d);
        @(negedge clk);
        bus_cs = 1; bus_rd = 1; bus_off = o[3:0];
        #5 d = bus_rdata;
        @(negedge clk);
        bus_cs = 0; bus_rd = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R12 mask", mask, 4'hF);
        check("R12 cmd", cmd, 0);
        check("R12 addr", cur_addr, 0);
        check("R12 mode", mode, 0);

        wr_reg(12, 0);
        wr_reg(2, 'h34); wr_reg(2, 'h12);
        check("R2 ch1 addr", cur_addr[31:16], 'h1234);
        wr_reg(3, 'hFF); wr_reg(3, 'h00);
        check("R2 ch1 cnt", cur_cnt[31:16], 'h00FF);
        rd_reg(2, d); check("R1 low byte", d, 'h34);
        rd_reg(2, d); check("R1 high byte", d, 'h12);
        wr_reg(0, 'h77); wr_reg(12, 0);
        rd_reg(0, d); check("R1 after clear", d, 'h77);
        wr_reg(12, 0);

        wr_reg(11, 'h45); check("R4 ch1 io-to-mem", mode[11:6], 'h11);
        wr_reg(11, 'h4B); check("R4 ch3 mem-to-io", mode[23:18], 'h12);
        wr_reg(11, 'hC0); check("R4 ch0 cascade", mode[5:0], 'h30);

        wr_reg(10, 'h01); check("R3 clear ch1", mask, 4'b1101);
        wr_reg(10, 'h05); check("R3 set ch1", mask, 4'b1111);
        wr_reg(14, 0);    check("R8 clear all", mask, 4'h0);
        wr_reg(15, 'h3A); check("R8 load all", mask, 4'hA);

        wr_reg(8, 'h5A);  check("R5 cmd", cmd, 'h5A);
        wr_reg(9, 'h06);  check("R5 sreq set", sreq, 4'b0100);
        wr_reg(9, 'h07);  check("R5 sreq set ch3", sreq, 4'b1100);
        wr_reg(9, 'h03);  check("R5 sreq clear ch3", sreq, 4'b0100);

        @(negedge clk); eng_req = 4'b0001; eng_tc = 4'b0010;
        @(negedge clk); eng_tc = 0;
        rd_reg(8, d); check("R6 status", d, 'h52);
        rd_reg(8, d); check("R6 cleared", d, 'h50);
        @(negedge clk);
        bus_cs = 1; bus_rd = 1; bus_off = 8; eng_tc = 4'b1000;
        #5 check("R6 read before tc", bus_rdata, 'h50);
        @(negedge clk); bus_cs = 0; bus_rd = 0; eng_tc = 0;
        rd_reg(8, d); check("R6 tc kept", d, 'h58);
        rd_reg(8, d); check("R6 cleared again", d, 'h50);
        eng_req = 0;

        wr_reg(12, 0);
        wr_reg(4, 'h00); wr_reg(4, 'h10);
        wr_reg(5, 'hFF); wr_reg(5, 'h00);
        wr_reg(11, 'h56);
        @(negedge clk); eng_ld = 4'b0100; eng_addr[47:32] = 'h1080; eng_cnt[47:32] = 'h007F;
        @(negedge clk); eng_ld = 0;
        check("R9 engine addr", cur_addr[47:32], 'h1080);
        check("R9 engine cnt", cur_cnt[47:32], 'h007F);
        @(negedge clk); eng_tc = 4'b0110;
        @(negedge clk); eng_tc = 0;
        check("R10 reload addr", cur_addr[47:32], 'h1000);
        check("R10 reload cnt", cur_cnt[47:32], 'h00FF);
        check("R10 no autoinit", cur_addr[31:16], 'h1234);
        @(negedge clk); eng_ld = 4'b0100; eng_tc = 4'b0100; eng_addr[47:32] = 'h2222;
        @(negedge clk); eng_ld = 0; eng_tc = 0;
        check("R10 reload beats load", cur_addr[47:32], 'h1000);

        @(negedge clk);
        bus_cs = 1; bus_wr = 1; bus_off = 0; bus_wdata = 'h99;
        eng_ld = 4'b0001; eng_addr[15:0] = 'hBEEF; eng_cnt[15:0] = 'hCAFE;
        @(negedge clk); bus_cs = 0; bus_wr = 0; eng_ld = 0;
        check("R9 bus wins addr", cur_addr[15:0], 'h0099);
        check("R9 engine cnt", cur_cnt[15:0], 'hCAFE);
        wr_reg(12, 0);

        @(negedge clk); eng_temp_ld = 1; eng_temp = 'hA5;
        @(negedge clk); eng_temp_ld = 0;
        rd_reg(13, d); check("R11 temp", d, 'hA5);
        rd_reg(9, d);  check("R11 write-only reads zero", d, 0);
        rd_reg(0, d);  check("R11 pointer unmoved", d, 'h99);
        wr_reg(8, 'h11);

        wr_reg(13, 0);
        check("R7 masks", mask, 4'hF);
        check("R7 cmd", cmd, 0);
        check("R7 sreq", sreq, 0);
        check("R7 mode kept", mode[11:6], 'h11);
        rd_reg(13, d); check("R7 temp", d, 0);
        rd_reg(2, d);  check("R7 addr kept, pointer low", d, 'h34);
        rd_reg(8, d);  check("R7 status", d, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule